// File: doc/BRIEF.md
# Four-Channel 8-Bit Pulse-Width Modulator with Host-Written Setpoints

This block drives four pulse-width outputs, each with 8-bit duty resolution, for use as filtered DAC outputs or as switched drive for motors and solenoids. All four channels compare against one shared free-running counter that advances on every clock, with no prescaler. A counter period is therefore 256 clocks. A channel's output is high while the counter is below that channel's setpoint, which gives a duty of setpoint/256.

A host writes the setpoints over a small 8-bit microcontroller-style bus. The bus has an active-low select, an active-low write strobe and a 2-bit channel address. A write lands in a staging register. The staged value moves into the channel's working setpoint only when the counter wraps from 255 to 0, so a period already under way is never cut short or stretched.

A setpoint of zero is trapped, and the output stays flat low. A mode input changes this so that every channel always carries a waveform: zero then yields a single high clock per period, and 255 yields a single low clock. Reset clears the counter and every setpoint, so all outputs stay low until a value is written.

Top module: `pwm_quad`

## Requirements
- R1: While reset is asserted, and afterwards until a nonzero setpoint has been written and loaded, every output is low. Reset clears all staged and working setpoints and the counter.
- R2: On a rising clock edge where `bus_cs_n` = 0 and `bus_wr_n` = 0, `bus_data` is stored as the staged setpoint of the channel numbered by `bus_addr` (0 to 3). Channel k drives `pwm_out[k]`.
- R3: A write cycle with `bus_cs_n` = 1 changes no setpoint, even if `bus_wr_n` = 0.
- R4: With `wave_keep` = 0 and a setpoint S from 1 to 255, the output is high for exactly S clocks out of every 256.
- R5: With `wave_keep` = 0, a setpoint of 0 holds the output low on every clock, with no pulse.
- R6: With `wave_keep` = 1, a setpoint of 0 gives exactly 1 high clock per 256, and a setpoint of 255 gives exactly 1 low clock per 256.
- R7: The shared counter advances by one on every clock and wraps from 255 to 0, so each output repeats with a period of 256 clocks.
- R8: A newly staged setpoint takes effect only at the counter wrap from 255 to 0. The rest of the current period keeps the old setpoint.
- R9: Each channel's duty depends only on its own setpoint. Writing one channel leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low bus select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | 2 | Channel number for the write |
| bus_data | input | 8 | Setpoint value being written |
| wave_keep | input | 1 | 1 = always produce a waveform, including for setpoint 0 |
| pwm_out | output | 4 | Pulse outputs, bit k = channel k |

## Verification
A write is staged at the clock edge where select and strobe are both low. It reaches the output only after the next wrap, plus one cycle for the output register, so the bench waits more than two full periods after each write before it measures. Duty is checked by counting high samples over any 256 consecutive clocks. Because the waveform repeats every 256 clocks, this count equals the setpoint no matter where the window starts.

For the deferred-load check, the bench first finds a falling edge of the output, which places the counter just past the old setpoint. It then writes a larger value and confirms that the output stays low for the next 100 clocks, a span that ends before the wrap. The period check measures the distance between consecutive rising edges. All outputs are sampled on the falling clock edge.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_RES_W  = 8;

    function automatic int addr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
    parameter int RES_W = pwm_quad_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RES_W-1:0] cnt,
    output logic             wrap
);
    typedef struct packed {
        logic [RES_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = (st_q.cnt == {RES_W{1'b1}});
endmodule

// File: rtl/pwm_setpoint_bank.sv
module pwm_setpoint_bank #(
    parameter int NUM_CH = pwm_quad_pkg::DEF_NUM_CH,
    parameter int RES_W  = pwm_quad_pkg::DEF_RES_W,
    parameter int ADDR_W = pwm_quad_pkg::addr_width(NUM_CH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_cs_n,
    input  logic                         bus_wr_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [RES_W-1:0]             bus_data,
    output logic [NUM_CH-1:0][RES_W-1:0] staged
);
    typedef struct packed {
        logic [NUM_CH-1:0][RES_W-1:0] stg;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    logic [NUM_CH-1:0] hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign hit[g] = !bus_cs_n && !bus_wr_n && (bus_addr == ADDR_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit[i]) st_d.stg[i] = bus_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign staged = st_q.stg;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int RES_W = pwm_quad_pkg::DEF_RES_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [RES_W-1:0] cnt,
    input  logic [RES_W-1:0] staged,
    input  logic             wave_keep,
    output logic [RES_W-1:0] active,
    output logic             pwm
);
    typedef struct packed {
        logic [RES_W-1:0] act;
        logic             out;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      below, zero_trap, floor_pulse;

    always_comb begin
        below       = (cnt < st_q.act);
        zero_trap   = (st_q.act == '0) && !wave_keep;
        floor_pulse = wave_keep && (cnt == '0);
        st_d        = st_q;
        st_d.out    = !zero_trap && (below || floor_pulse);
        if (wrap) st_d.act = staged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;
    assign pwm    = st_q.out;
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
    parameter int NUM_CH = pwm_quad_pkg::DEF_NUM_CH,
    parameter int RES_W  = pwm_quad_pkg::DEF_RES_W,
    localparam int ADDR_W = pwm_quad_pkg::addr_width(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [RES_W-1:0]  bus_data,
    input  logic              wave_keep,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [RES_W-1:0]             cnt_w;
    logic                         wrap_w;
    logic [NUM_CH-1:0][RES_W-1:0] stg_w;
    logic [NUM_CH-1:0][RES_W-1:0] act_w;

    pwm_tick_counter #(.RES_W(RES_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .cnt  (cnt_w),
        .wrap (wrap_w)
    );

    pwm_setpoint_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_cs_n(bus_cs_n),
        .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr),
        .bus_data(bus_data),
        .staged  (stg_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.RES_W(RES_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wrap     (wrap_w),
            .cnt      (cnt_w),
            .staged   (stg_w[g]),
            .wave_keep(wave_keep),
            .active   (act_w[g]),
            .pwm      (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_quad_checker.sv
module pwm_quad_checker #(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 8,
    parameter int ADDR_W = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_cs_n,
    input logic                         bus_wr_n,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [RES_W-1:0]             bus_data,
    input logic                         wave_keep,
    input logic [RES_W-1:0]             cnt,
    input logic                         wrap,
    input logic [NUM_CH-1:0][RES_W-1:0] stg,
    input logic [NUM_CH-1:0][RES_W-1:0] act,
    input logic [NUM_CH-1:0]            pwm
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == RES_W'($past(cnt) + 1'b1)); // R7
    AST_DESELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |=> $stable(stg)); // R3
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act)); // R8
    AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> act == $past(stg)); // R8

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_WRITE_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_cs_n && !bus_wr_n && bus_addr == ADDR_W'(g)) |=> stg[g] == $past(bus_data)); // R2
        AST_ZERO_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
            (act[g] == '0 && !wave_keep) |=> !pwm[g]); // R5
        AST_HIGH_NEEDS_SETPOINT: assert property (@(posedge clk) disable iff (!rst_n)
            pwm[g] |-> $past(act[g] != '0 || wave_keep)); // R4
    end
endmodule

bind pwm_quad pwm_quad_checker #(.NUM_CH(NUM_CH), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_wr_n (bus_wr_n),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .wave_keep(wave_keep),
    .cnt      (cnt_w),
    .wrap     (wrap_w),
    .stg      (stg_w),
    .act      (act_w),
    .pwm      (pwm_out)
);

// File: tb/pwm_quad_bench.sv
module pwm_quad_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_cs_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_data = '0;
    logic       wave_keep = 1'b0;
    logic [3:0] pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    int hi_cnt[4];
    bit finished = 0;

    always #4 clk = ~clk;

    pwm_quad u_pwm_quad (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_data(bus_data), .wave_keep(wave_keep),
        .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input int ch, input int val, input bit sel);
        bus_addr = 2'(ch); bus_data = 8'(val);
        bus_cs_n = !sel;   bus_wr_n = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1;   bus_wr_n = 1'b1;
    endtask

    task automatic measure();
        for (int i = 0; i < 4; i++) hi_cnt[i] = 0;
        repeat (256) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (pwm_out[i]) hi_cnt[i]++;
        end
    endtask

    task automatic t_reset_state();
        check("R1 outputs in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        cycles(1);
        measure();
        for (int i = 0; i < 4; i++) check("R1 low after reset", hi_cnt[i], 0);
    endtask

    task automatic t_duty_per_channel();
        bus_write(0, 1, 1); bus_write(1, 64, 1);
        bus_write(2, 200, 1); bus_write(3, 255, 1);
        cycles(600);
        measure();
        check("R4 duty ch0=1", hi_cnt[0], 1);
        check("R2 addr1 duty 64", hi_cnt[1], 64);
        check("R4 duty ch2=200", hi_cnt[2], 200);
        check("R4 duty ch3=255", hi_cnt[3], 255);
    endtask

    task automatic t_independent();
        bus_write(2, 17, 1);
        cycles(600);
        measure();
        check("R9 ch2 rewritten", hi_cnt[2], 17);
        check("R9 ch0 untouched", hi_cnt[0], 1);
        check("R9 ch1 untouched", hi_cnt[1], 64);
        check("R9 ch3 untouched", hi_cnt[3], 255);
    endtask

    task automatic t_deselect();
        bus_write(1, 5, 0);
        cycles(600);
        measure();
        check("R3 deselected write ignored", hi_cnt[1], 64);
    endtask

    task automatic t_zero();
        int seen = 0;
        bus_write(0, 0, 1);
        cycles(600);
        repeat (512) begin
            @(negedge clk);
            if (pwm_out[0]) seen++;
        end
        check("R5 zero flat low", seen, 0);
    endtask

    task automatic t_keep_mode();
        bus_write(3, 255, 1);
        wave_keep = 1'b1;
        cycles(600);
        measure();
        check("R6 keep zero one high", hi_cnt[0], 1);
        check("R6 keep 255 one low", 256 - hi_cnt[3], 1);
        check("R6 keep normal duty", hi_cnt[1], 64);
        wave_keep = 1'b0;
        cycles(300);
    endtask

    task automatic t_period();
        int gap = 0;
        bit prev;
        prev = pwm_out[1];
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[1]) break;
            prev = pwm_out[1];
        end
        prev = pwm_out[1];
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            gap++;
            if (!prev && pwm_out[1]) break;
            prev = pwm_out[1];
        end
        check("R7 period", gap, 256);
    endtask

    task automatic t_deferred();
        int seen = 0;
        bit prev;
        bus_write(0, 128, 1);
        cycles(600);
        prev = pwm_out[0];
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (prev && !pwm_out[0]) break;
            prev = pwm_out[0];
        end
        bus_write(0, 200, 1);
        repeat (100) begin
            @(negedge clk);
            if (pwm_out[0]) seen++;
        end
        check("R8 no change before wrap", seen, 0);
        cycles(300);
        measure();
        check("R8 new value after wrap", hi_cnt[0], 200);
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0;
        cycles(3);
        check("R1 outputs during reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        cycles(300);
        measure();
        for (int i = 0; i < 4; i++) check("R1 setpoints cleared", hi_cnt[i], 0);
    endtask

    initial begin
        cycles(4);
        t_reset_state();
        t_duty_per_channel();
        t_independent();
        t_deselect();
        t_zero();
        t_keep_mode();
        t_period();
        t_deferred();
        t_reset_clears();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule